// File: doc/BRIEF.md
# Cache miss entry with primary and deferred target lists

This block is one miss-handling entry of a non-blocking cache. Once a miss is allocated it holds the block address, a ready time and an order tag. Every request that hits the same block while the miss is outstanding is queued behind it as a target. Targets go into one of two bounded FIFO lists. The primary list holds the requests that the current fill will satisfy. The deferred list holds the requests that must wait for a second request downstream.

The list is chosen by coherence rules. These look at whether the fill in flight will be writable, whether a snoop has already taken the line away, and whether a snoop will downgrade it. When a target is deferred behind a pending invalidation, its command is rewritten. When a fill comes back, the deferred list can be folded into the primary list, or promoted to become the new primary list.

The entry is driven by one operation code per cycle. Every operation that breaks its precondition is flagged on a combinational `illegal` output and has no effect.

Top module: `miss_entry_tracker`

## Requirements
- R1: After reset, busy, in_service, pend_mod, ds_pending, post_inval and post_down are 0, both counts are 0, head_valid is 0, and the list flags are 0.
- R2: op 1 (allocate) while idle loads the address, ready time and order tag. It puts one marked target in the primary list, with source 2 (prefetcher) if req_cmd is 5 (prefetch), otherwise source 0 (CPU). It clears in_service, pend_mod and ds_pending and sets busy. Allocate while busy is illegal.
- R3: An accepted non-snoop target sets its list's needs-writable flag for commands 1 (read-exclusive), 2 (upgrade), 3 (store-conditional), 4 (failed store-conditional) and 6 (write). It sets the list's upgrade flag for commands 2 and 3. Command 0 is a plain read.
- R4: op 2 (add) sends a non-snoop target to the deferred list when in_service is set and at least one of these holds: the deferred list is non-empty; post_inval is set; or the command needs writable and pend_mod is low, or post_down is set, or is_forward is set. Otherwise the target goes to the primary list. add_to_def shows the choice. post_inval and post_down are set by snoop_inval and snoop_down while busy, and are cleared by allocate, service and deallocate.
- R5: A primary-list target from the CPU is marked pending only if the entry is not in service. Deferred targets are always marked. Snoop targets (req_snoop=1, source 1) always go to the primary list unmarked and leave the list flags unchanged.
- R6: When a target is deferred while post_inval is set, command 2 is stored as 1 and command 3 is stored as 4.
- R7: An add whose destination list already holds DEPTH targets raises stall and is not accepted. Neither count ever exceeds DEPTH.
- R8: An add while idle, after an uncacheable allocation, or with command 5 is illegal and is ignored.
- R9: op 3 (service) while busy and not in service sets in_service. It sets pend_mod to the primary needs-writable flag OR pm_resp, and clears post_inval and post_down. A second service is illegal.
- R10: op 5 (promote) needs an empty primary list. With an empty deferred list it does nothing and promote_ok is 0. Otherwise promote_ok is 1, the deferred list and its flags become the primary list, the deferred flags clear, and order_tag takes the head's order. ready_time becomes the later of now_time and the head's ready time, and in_service clears.
- R11: op 4 (response) with resp_writable, while in service, with a deferred list that needs writable and is non-empty, and with neither post flag set, appends all deferred targets to the primary list in order. It sets the primary needs-writable flag and clears the deferred list and flags. If the combined count would exceed DEPTH, nothing changes. A response while not in service is illegal.
- R12: op 6 (deallocate) with both lists empty clears busy, in_service, pend_mod and every flag. Otherwise it is illegal.
- R13: op 7 (pop) removes the primary head. Targets leave in arrival order, and the head_* outputs show the oldest one. Pop with an empty primary list is illegal.
- R14: op 8 sets and op 9 clears ds_pending while busy. While idle, either op is illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 4 | Operation code (0 means no operation) |
| req_id | input | TID_W | Request identifier |
| req_cmd | input | 3 | Request command |
| req_snoop | input | 1 | Target comes from a snoop |
| req_ready | input | TIME_W | Ready time of the request |
| req_order | input | ORD_W | Order tag of the request |
| req_addr | input | ADDR_W | Block address at allocation |
| req_uncache | input | 1 | Allocation is uncacheable |
| resp_writable | input | 1 | Fill being returned is writable |
| pm_resp | input | 1 | Writable response expected anyway, used at service |
| is_forward | input | 1 | Entry forwards its fill |
| snoop_inval | input | 1 | Snoop will invalidate after the fill |
| snoop_down | input | 1 | Snoop will downgrade after the fill |
| now_time | input | TIME_W | Current time |
| busy | output | 1 | Entry is allocated |
| in_service | output | 1 | Request issued downstream |
| pend_mod | output | 1 | Writable fill expected |
| ds_pending | output | 1 | Downstream still buffers the request |
| post_inval | output | 1 | Invalidation pending after fill |
| post_down | output | 1 | Downgrade pending after fill |
| blk_addr | output | ADDR_W | Block address |
| ready_time | output | TIME_W | Entry ready time |
| order_tag | output | ORD_W | Entry order tag |
| pri_count | output | CW | Primary list occupancy |
| def_count | output | CW | Deferred list occupancy |
| pri_nw | output | 1 | Primary list needs writable |
| pri_upg | output | 1 | Primary list holds an upgrade |
| def_nw | output | 1 | Deferred list needs writable |
| def_upg | output | 1 | Deferred list holds an upgrade |
| head_valid | output | 1 | Primary list non-empty |
| head_id | output | TID_W | Primary head identifier |
| head_cmd | output | 3 | Primary head command |
| head_src | output | 2 | Primary head source |
| head_marked | output | 1 | Primary head marked pending |
| add_to_def | output | 1 | Current add is routed to the deferred list |
| stall | output | 1 | Current add refused, destination full |
| illegal | output | 1 | Current operation breaks a precondition |
| promote_ok | output | 1 | Current promote moves targets |

## Verification
The bench builds the entry with DEPTH=4 instead of 8. With that depth a handful of adds fills either list, so the stall path is reached often. It also puts the overflow case of the writable merge (four primary targets plus one deferred) within a short directed sequence. Random episodes then mix commands, snoop flags and out-of-order operations, which exercises every deferral clause and every illegal-operation case against a queue-based model.

// File: rtl/mtt_pkg.sv
package mtt_pkg;
  parameter int TID_W  = 4;
  parameter int TIME_W = 16;
  parameter int ORD_W  = 8;

  typedef enum logic [2:0] {
    C_READ = 3'd0, C_READEX = 3'd1, C_UPGRADE = 3'd2, C_STCOND = 3'd3,
    C_STFAIL = 3'd4, C_PREFETCH = 3'd5, C_WRITE = 3'd6, C_RSVD = 3'd7
  } cmd_e;

  typedef enum logic [1:0] {S_CPU = 2'd0, S_SNOOP = 2'd1, S_PREF = 2'd2, S_NONE = 2'd3} src_e;

  typedef enum logic [3:0] {
    OP_NOP = 4'd0, OP_ALLOC = 4'd1, OP_ADD = 4'd2, OP_SERVICE = 4'd3,
    OP_RESP = 4'd4, OP_PROMOTE = 4'd5, OP_DEALLOC = 4'd6, OP_POP = 4'd7,
    OP_DSSET = 4'd8, OP_DSCLR = 4'd9
  } op_e;

  typedef struct packed {
    logic [TID_W-1:0]  id;
    src_e              src;
    cmd_e              cmd;
    logic              marked;
    logic [TIME_W-1:0] ready;
    logic [ORD_W-1:0]  order;
  } tgt_t;

  function automatic logic wants_writable(cmd_e c);
    return c inside {C_READEX, C_UPGRADE, C_STCOND, C_STFAIL, C_WRITE};
  endfunction

  function automatic logic is_upgrade(cmd_e c);
    return c inside {C_UPGRADE, C_STCOND};
  endfunction

  function automatic cmd_e after_inval(cmd_e c);
    case (c)
      C_UPGRADE: return C_READEX;
      C_STCOND:  return C_STFAIL;
      default:   return c;
    endcase
  endfunction

  function automatic logic [TIME_W-1:0] later_of(logic [TIME_W-1:0] a, logic [TIME_W-1:0] b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/mtt_route.sv
module mtt_route
  import mtt_pkg::*;
(
  input  logic in_svc,
  input  logic def_nonempty,
  input  logic post_inv,
  input  logic post_dn,
  input  logic pend_mod,
  input  logic fwd,
  input  logic snoop,
  input  cmd_e cmd_in,
  output logic to_def,
  output cmd_e cmd_out,
  output logic mark
);
  logic wr_block;
  assign wr_block = wants_writable(cmd_in) && (!pend_mod || post_dn || fwd);
  assign to_def   = !snoop && in_svc && (def_nonempty || post_inv || wr_block);
  assign cmd_out  = (to_def && post_inv) ? after_inval(cmd_in) : cmd_in;
  assign mark     = snoop ? 1'b0 : (to_def ? 1'b1 : !in_svc);
endmodule

// File: rtl/mtt_list.sv
module mtt_list
  import mtt_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  push,
  input  tgt_t                  push_ent,
  input  logic                  pop,
  input  logic                  append,
  input  tgt_t [DEPTH-1:0]      app_ents,
  input  logic [CW-1:0]         app_cnt,
  input  logic                  clear,
  output tgt_t [DEPTH-1:0]      ents,
  output logic [CW-1:0]         cnt,
  output logic                  full,
  output logic                  empty
);
  tgt_t [DEPTH-1:0] nxt;
  logic [CW-1:0]    ncnt;

  always_comb begin
    nxt  = ents;
    ncnt = cnt;
    if (clear) begin
      ncnt = '0;
    end else if (append) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (i >= int'(cnt) && i < int'(cnt) + int'(app_cnt))
          nxt[i] = app_ents[IW'(i - int'(cnt))];
      end
      ncnt = cnt + app_cnt;
    end else begin
      if (pop) begin
        for (int i = 0; i < DEPTH - 1; i++) nxt[i] = ents[i+1];
        nxt[DEPTH-1] = '0;
        ncnt = cnt - 1'b1;
      end
      if (push) begin
        nxt[IW'(ncnt)] = push_ent;
        ncnt = ncnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ents <= '0;
      cnt  <= '0;
    end else begin
      ents <= nxt;
      cnt  <= ncnt;
    end
  end

  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);
endmodule

// File: rtl/miss_entry_tracker.sv
module miss_entry_tracker
  import mtt_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        op,
  input  logic [TID_W-1:0]  req_id,
  input  logic [2:0]        req_cmd,
  input  logic              req_snoop,
  input  logic [TIME_W-1:0] req_ready,
  input  logic [ORD_W-1:0]  req_order,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_uncache,
  input  logic              resp_writable,
  input  logic              pm_resp,
  input  logic              is_forward,
  input  logic              snoop_inval,
  input  logic              snoop_down,
  input  logic [TIME_W-1:0] now_time,
  output logic              busy,
  output logic              in_service,
  output logic              pend_mod,
  output logic              ds_pending,
  output logic              post_inval,
  output logic              post_down,
  output logic [ADDR_W-1:0] blk_addr,
  output logic [TIME_W-1:0] ready_time,
  output logic [ORD_W-1:0]  order_tag,
  output logic [CW-1:0]     pri_count,
  output logic [CW-1:0]     def_count,
  output logic              pri_nw,
  output logic              pri_upg,
  output logic              def_nw,
  output logic              def_upg,
  output logic              head_valid,
  output logic [TID_W-1:0]  head_id,
  output logic [2:0]        head_cmd,
  output logic [1:0]        head_src,
  output logic              head_marked,
  output logic              add_to_def,
  output logic              stall,
  output logic              illegal,
  output logic              promote_ok
);
  op_e  opc;
  cmd_e rcmd, route_cmd;
  logic route_def, route_mark, uncache;
  logic p_full, p_empty, d_full, d_empty;
  tgt_t [DEPTH-1:0] p_ents, d_ents;
  tgt_t alloc_ent, add_ent;
  logic [CW:0] both_cnt;

  assign opc  = op_e'(op);
  assign rcmd = cmd_e'(req_cmd);

  mtt_route u_route (
    .in_svc(in_service), .def_nonempty(!d_empty), .post_inv(post_inval),
    .post_dn(post_down), .pend_mod(pend_mod), .fwd(is_forward), .snoop(req_snoop),
    .cmd_in(rcmd), .to_def(route_def), .cmd_out(route_cmd), .mark(route_mark)
  );

  // Named events, also used by the bound checker
  logic add_bad, evt_add, evt_alloc, evt_service, evt_merge, evt_promote;
  logic evt_dealloc, evt_pop, evt_ds, prom_legal;
  assign add_bad     = (opc == OP_ADD) && (!busy || uncache || rcmd == C_PREFETCH);
  assign add_to_def  = (opc == OP_ADD) && busy && route_def;
  assign stall       = (opc == OP_ADD) && !add_bad && (route_def ? d_full : p_full);
  assign evt_add     = (opc == OP_ADD) && !add_bad && !stall;
  assign evt_alloc   = (opc == OP_ALLOC) && !busy;
  assign evt_service = (opc == OP_SERVICE) && busy && !in_service;
  assign both_cnt    = {1'b0, pri_count} + {1'b0, def_count};
  assign evt_merge   = (opc == OP_RESP) && in_service && resp_writable && def_nw && !d_empty
                       && !post_inval && !post_down && (both_cnt <= (CW+1)'(DEPTH));
  assign prom_legal  = (opc == OP_PROMOTE) && busy && p_empty;
  assign evt_promote = prom_legal && !d_empty;
  assign promote_ok  = evt_promote;
  assign evt_dealloc = (opc == OP_DEALLOC) && busy && p_empty && d_empty;
  assign evt_pop     = (opc == OP_POP) && busy && !p_empty;
  assign evt_ds      = (opc == OP_DSSET || opc == OP_DSCLR) && busy;

  always_comb begin
    case (opc)
      OP_ALLOC:             illegal = busy;
      OP_ADD:               illegal = add_bad;
      OP_SERVICE:           illegal = !evt_service;
      OP_RESP:              illegal = !in_service;
      OP_PROMOTE:           illegal = !prom_legal;
      OP_DEALLOC:           illegal = !evt_dealloc;
      OP_POP:               illegal = !evt_pop;
      OP_DSSET, OP_DSCLR:   illegal = !busy;
      default:              illegal = 1'b0;
    endcase
  end

  always_comb begin
    alloc_ent = '{id: req_id, src: (rcmd == C_PREFETCH) ? S_PREF : S_CPU, cmd: rcmd,
                  marked: 1'b1, ready: req_ready, order: req_order};
    add_ent   = '{id: req_id, src: req_snoop ? S_SNOOP : S_CPU, cmd: route_cmd,
                  marked: route_mark, ready: req_ready, order: req_order};
  end

  mtt_list #(.DEPTH(DEPTH)) u_pri (
    .clk(clk), .rst_n(rst_n),
    .push(evt_alloc || (evt_add && !route_def)),
    .push_ent(evt_alloc ? alloc_ent : add_ent),
    .pop(evt_pop), .append(evt_merge || evt_promote),
    .app_ents(d_ents), .app_cnt(def_count), .clear(1'b0),
    .ents(p_ents), .cnt(pri_count), .full(p_full), .empty(p_empty)
  );

  mtt_list #(.DEPTH(DEPTH)) u_def (
    .clk(clk), .rst_n(rst_n),
    .push(evt_add && route_def), .push_ent(add_ent),
    .pop(1'b0), .append(1'b0), .app_ents(p_ents), .app_cnt('0),
    .clear(evt_merge || evt_promote),
    .ents(d_ents), .cnt(def_count), .full(d_full), .empty(d_empty)
  );

  logic post_clr;
  assign post_clr = evt_alloc || evt_service || evt_dealloc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; in_service <= 1'b0; pend_mod <= 1'b0; ds_pending <= 1'b0;
      post_inval <= 1'b0; post_down <= 1'b0; uncache <= 1'b0;
      blk_addr <= '0; ready_time <= '0; order_tag <= '0;
      pri_nw <= 1'b0; pri_upg <= 1'b0; def_nw <= 1'b0; def_upg <= 1'b0;
    end else begin
      post_inval <= (post_inval && !post_clr) || (busy && snoop_inval);
      post_down  <= (post_down && !post_clr) || (busy && snoop_down);
      if (evt_alloc) begin
        busy <= 1'b1; in_service <= 1'b0; pend_mod <= 1'b0; ds_pending <= 1'b0;
        uncache <= req_uncache; blk_addr <= req_addr;
        ready_time <= req_ready; order_tag <= req_order;
        pri_nw <= wants_writable(rcmd); pri_upg <= is_upgrade(rcmd);
        def_nw <= 1'b0; def_upg <= 1'b0;
      end
      if (evt_add && !req_snoop) begin
        if (route_def) begin
          def_nw  <= def_nw  || wants_writable(route_cmd);
          def_upg <= def_upg || is_upgrade(route_cmd);
        end else begin
          pri_nw  <= pri_nw  || wants_writable(route_cmd);
          pri_upg <= pri_upg || is_upgrade(route_cmd);
        end
      end
      if (evt_service) begin
        in_service <= 1'b1;
        pend_mod   <= pri_nw || pm_resp;
      end
      if (evt_merge) begin
        pri_nw <= 1'b1; pri_upg <= pri_upg || def_upg;
        def_nw <= 1'b0; def_upg <= 1'b0;
      end
      if (evt_promote) begin
        pri_nw <= def_nw; pri_upg <= def_upg;
        def_nw <= 1'b0; def_upg <= 1'b0;
        order_tag  <= d_ents[0].order;
        ready_time <= later_of(now_time, d_ents[0].ready);
        in_service <= 1'b0;
      end
      if (evt_dealloc) begin
        busy <= 1'b0; in_service <= 1'b0; pend_mod <= 1'b0; ds_pending <= 1'b0;
        uncache <= 1'b0;
        pri_nw <= 1'b0; pri_upg <= 1'b0; def_nw <= 1'b0; def_upg <= 1'b0;
      end
      if (evt_ds) ds_pending <= (opc == OP_DSSET);
    end
  end

  assign head_valid  = !p_empty;
  assign head_id     = p_ents[0].id;
  assign head_cmd    = p_ents[0].cmd;
  assign head_src    = p_ents[0].src;
  assign head_marked = p_ents[0].marked;
endmodule

// File: rtl/mtt_checker.sv
module mtt_checker #(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          stall,
  input logic          illegal,
  input logic          promote_ok,
  input logic          add_to_def,
  input logic          evt_add,
  input logic          evt_service,
  input logic          evt_merge,
  input logic          evt_dealloc,
  input logic          pm_resp,
  input logic          pri_nw,
  input logic          busy,
  input logic          in_service,
  input logic          pend_mod,
  input logic [CW-1:0] pri_count,
  input logic [CW-1:0] def_count
);
  assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pri_count <= CW'(DEPTH) && def_count <= CW'(DEPTH));

  assert_stall_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(pri_count) && $stable(def_count)));

  assert_illegal_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> ($stable(pri_count) && $stable(def_count) && $stable(in_service) && $stable(busy)));

  assert_defer_grows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_add && add_to_def) |=> (def_count == $past(def_count) + CW'(1)));

  assert_service_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_service |=> (in_service && pend_mod == ($past(pri_nw) || $past(pm_resp))));

  assert_promote_moves_R10: assert property (@(posedge clk) disable iff (!rst_n)
    promote_ok |=> (def_count == '0 && pri_count == $past(def_count) && !in_service));

  assert_merge_moves_R11: assert property (@(posedge clk) disable iff (!rst_n)
    evt_merge |=> (pri_nw && def_count == '0 && pri_count == $past(pri_count) + $past(def_count)));

  assert_dealloc_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    evt_dealloc |=> (!busy && !in_service && !pend_mod));
endmodule

bind miss_entry_tracker mtt_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .stall(stall), .illegal(illegal), .promote_ok(promote_ok),
  .add_to_def(add_to_def), .evt_add(evt_add), .evt_service(evt_service),
  .evt_merge(evt_merge), .evt_dealloc(evt_dealloc), .pm_resp(pm_resp), .pri_nw(pri_nw),
  .busy(busy), .in_service(in_service), .pend_mod(pend_mod),
  .pri_count(pri_count), .def_count(def_count)
);

// File: tb/miss_entry_tracker_bench.sv
module miss_entry_tracker_bench;
  import mtt_pkg::*;
  localparam int DEPTH = 4;
  localparam int AW = 32;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] op = 4'd0;
  logic [TID_W-1:0] req_id = '0;
  logic [2:0] req_cmd = '0;
  logic req_snoop = 0, req_uncache = 0, resp_writable = 0, pm_resp = 0;
  logic is_forward = 0, snoop_inval = 0, snoop_down = 0;
  logic [TIME_W-1:0] req_ready = '0, now_time = '0;
  logic [ORD_W-1:0] req_order = '0;
  logic [AW-1:0] req_addr = '0;
  logic busy, in_service, pend_mod, ds_pending, post_inval, post_down;
  logic [AW-1:0] blk_addr;
  logic [TIME_W-1:0] ready_time;
  logic [ORD_W-1:0] order_tag;
  logic [CW-1:0] pri_count, def_count;
  logic pri_nw, pri_upg, def_nw, def_upg, head_valid, head_marked;
  logic [TID_W-1:0] head_id;
  logic [2:0] head_cmd;
  logic [1:0] head_src;
  logic add_to_def, stall, illegal, promote_ok;

  always #5 clk = ~clk;

  miss_entry_tracker #(.DEPTH(DEPTH), .ADDR_W(AW)) u_miss_entry_tracker (.*);

  int nchk = 0, nfail = 0;
  bit done = 0;

  // bench-side model of the entry
  tgt_t mp[$], md[$];
  bit m_busy, m_svc, m_pm, m_ds, m_pi, m_pd, m_unc, m_pnw, m_pupg, m_dnw, m_dupg;
  logic [TIME_W-1:0] m_ready;
  logic [ORD_W-1:0] m_order;

  function automatic bit f_nw(logic [2:0] c);
    return c == 1 || c == 2 || c == 3 || c == 4 || c == 6;
  endfunction
  function automatic bit f_upg(logic [2:0] c);
    return c == 2 || c == 3;
  endfunction
  function automatic logic [2:0] f_rewrite(logic [2:0] c);
    return (c == 2) ? 3'd1 : (c == 3) ? 3'd4 : c;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(op_e o, string tag);
    bit e_ill, e_stall, e_def, e_prom, e_merge, route, bad, clr, old_busy;
    logic [2:0] c;
    tgt_t t;
    @(negedge clk);
    op = o;
    #1;
    e_ill = 0; e_stall = 0; e_def = 0; e_prom = 0; e_merge = 0; clr = 0;
    old_busy = m_busy;
    c = req_cmd;
    route = m_svc && !req_snoop &&
            (md.size() > 0 || m_pi || (f_nw(c) && (!m_pm || m_pd || is_forward)));
    case (o)
      OP_ALLOC: e_ill = m_busy;
      OP_ADD: begin
        bad = !m_busy || m_unc || c == 5;
        e_ill = bad; e_def = m_busy && route;
        e_stall = !bad && (route ? md.size() == DEPTH : mp.size() == DEPTH);
      end
      OP_SERVICE: e_ill = !(m_busy && !m_svc);
      OP_RESP: begin
        e_ill = !m_svc;
        e_merge = m_svc && resp_writable && m_dnw && md.size() > 0 && !m_pi && !m_pd
                  && (mp.size() + md.size() <= DEPTH);
      end
      OP_PROMOTE: begin
        e_ill = !(m_busy && mp.size() == 0);
        e_prom = !e_ill && md.size() > 0;
      end
      OP_DEALLOC: e_ill = !(m_busy && mp.size() == 0 && md.size() == 0);
      OP_POP: e_ill = !(m_busy && mp.size() > 0);
      OP_DSSET, OP_DSCLR: e_ill = !m_busy;
      default: ;
    endcase
    chk("R8", {tag, " illegal"}, illegal, e_ill);
    chk("R7", {tag, " stall"}, stall, e_stall);
    chk("R4", {tag, " add_to_def"}, add_to_def, e_def);
    chk("R10", {tag, " promote_ok"}, promote_ok, e_prom);
    @(posedge clk);
    #1;
    op = 4'd0;
    if (!e_ill) begin
      case (o)
        OP_ALLOC: begin
          t = '{id: req_id, src: (c == 5) ? S_PREF : S_CPU, cmd: cmd_e'(c), marked: 1'b1,
                ready: req_ready, order: req_order};
          mp = {t}; md = {};
          m_busy = 1; m_svc = 0; m_pm = 0; m_ds = 0; m_unc = req_uncache; clr = 1;
          m_ready = req_ready; m_order = req_order;
          m_pnw = f_nw(c); m_pupg = f_upg(c); m_dnw = 0; m_dupg = 0;
        end
        OP_ADD: if (!e_stall) begin
          t = '{id: req_id, src: req_snoop ? S_SNOOP : S_CPU,
                cmd: cmd_e'((route && m_pi) ? f_rewrite(c) : c),
                marked: req_snoop ? 1'b0 : (route ? 1'b1 : !m_svc),
                ready: req_ready, order: req_order};
          if (route) begin
            md.push_back(t);
            m_dnw |= f_nw(t.cmd); m_dupg |= f_upg(t.cmd);
          end else begin
            mp.push_back(t);
            if (!req_snoop) begin m_pnw |= f_nw(t.cmd); m_pupg |= f_upg(t.cmd); end
          end
        end
        OP_SERVICE: begin m_svc = 1; m_pm = m_pnw || pm_resp; clr = 1; end
        OP_RESP: if (e_merge) begin
          foreach (md[i]) mp.push_back(md[i]);
          md = {}; m_pnw = 1; m_pupg |= m_dupg; m_dnw = 0; m_dupg = 0;
        end
        OP_PROMOTE: if (e_prom) begin
          mp = md; md = {};
          m_pnw = m_dnw; m_pupg = m_dupg; m_dnw = 0; m_dupg = 0;
          m_order = mp[0].order;
          m_ready = (now_time > mp[0].ready) ? now_time : mp[0].ready;
          m_svc = 0;
        end
        OP_DEALLOC: begin
          m_busy = 0; m_svc = 0; m_pm = 0; m_ds = 0; m_unc = 0; clr = 1;
          m_pnw = 0; m_pupg = 0; m_dnw = 0; m_dupg = 0;
        end
        OP_POP: void'(mp.pop_front());
        OP_DSSET: m_ds = 1;
        OP_DSCLR: m_ds = 0;
        default: ;
      endcase
    end
    m_pi = (m_pi && !clr) || (old_busy && snoop_inval);
    m_pd = (m_pd && !clr) || (old_busy && snoop_down);
    chk("R13", {tag, " pri_count"}, pri_count, mp.size());
    chk("R4", {tag, " def_count"}, def_count, md.size());
    chk("R12", {tag, " busy"}, busy, m_busy);
    chk("R9", {tag, " in_service"}, in_service, m_svc);
    chk("R9", {tag, " pend_mod"}, pend_mod, m_pm);
    chk("R14", {tag, " ds_pending"}, ds_pending, m_ds);
    chk("R4", {tag, " post_inval"}, post_inval, m_pi);
    chk("R4", {tag, " post_down"}, post_down, m_pd);
    chk("R3", {tag, " pri_nw"}, pri_nw, m_pnw);
    chk("R3", {tag, " pri_upg"}, pri_upg, m_pupg);
    chk("R3", {tag, " def_nw"}, def_nw, m_dnw);
    chk("R3", {tag, " def_upg"}, def_upg, m_dupg);
    chk("R13", {tag, " head_valid"}, head_valid, mp.size() > 0);
    if (mp.size() > 0) begin
      chk("R13", {tag, " head_id"}, head_id, mp[0].id);
      chk("R6", {tag, " head_cmd"}, head_cmd, mp[0].cmd);
      chk("R2", {tag, " head_src"}, head_src, mp[0].src);
      chk("R5", {tag, " head_marked"}, head_marked, mp[0].marked);
    end
    if (m_busy) begin
      chk("R10", {tag, " order_tag"}, order_tag, m_order);
      chk("R10", {tag, " ready_time"}, ready_time, m_ready);
    end
  endtask

  task automatic set_req(int id, int cmd, bit snp);
    req_id = TID_W'(id); req_cmd = 3'(cmd); req_snoop = snp;
    req_ready = TIME_W'($urandom_range(0, 200)); req_order = ORD_W'($urandom_range(0, 255));
  endtask

  task automatic snoop_pulse(bit inv, bit dn);
    snoop_inval = inv; snoop_down = dn;
    step(OP_NOP, "snoop");
    snoop_inval = 0; snoop_down = 0;
  endtask

  task automatic drain(string tag);
    for (int k = 0; k < 30 && (mp.size() > 0 || md.size() > 0); k++) begin
      if (mp.size() > 0) step(OP_POP, tag);
      else step(OP_PROMOTE, tag);
    end
    step(OP_DEALLOC, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R1: reset state
    chk("R1", "busy", busy, 0); chk("R1", "in_service", in_service, 0);
    chk("R1", "pend_mod", pend_mod, 0); chk("R1", "ds_pending", ds_pending, 0);
    chk("R1", "counts", pri_count + def_count, 0); chk("R1", "head_valid", head_valid, 0);
    chk("R1", "flags", pri_nw + pri_upg + def_nw + def_upg + post_inval + post_down, 0);

    // R8: add while idle; R2 prefetch allocate
    set_req(1, 0, 0); step(OP_ADD, "R8 idle add");
    set_req(2, 5, 0); req_addr = 32'h1000; step(OP_ALLOC, "R2 prefetch alloc");
    set_req(3, 5, 0); step(OP_ADD, "R8 prefetch add");
    step(OP_ALLOC, "R2 alloc while busy");
    step(OP_DSSET, "R14 set"); step(OP_SERVICE, "R9 service");
    step(OP_SERVICE, "R9 second service"); step(OP_DSCLR, "R14 clear");
    drain("R12 drain");

    // R11 merge, then R5 marking
    set_req(4, 0, 0); step(OP_ALLOC, "R11 alloc");
    pm_resp = 0; step(OP_SERVICE, "R11 service");
    set_req(5, 1, 0); step(OP_ADD, "R4 needs writable defer");
    set_req(6, 0, 1); step(OP_ADD, "R5 snoop add");
    resp_writable = 1; step(OP_RESP, "R11 merge"); resp_writable = 0;
    drain("R11 drain");

    // R11 overflow skip and R7 stall
    set_req(7, 0, 0); step(OP_ALLOC, "R11 ovf alloc");
    for (int i = 0; i < 4; i++) begin set_req(8 + i, 0, 0); step(OP_ADD, "R7 fill primary"); end
    step(OP_SERVICE, "R11 ovf service");
    set_req(12, 1, 0); step(OP_ADD, "R11 ovf defer");
    resp_writable = 1; step(OP_RESP, "R11 overflow skip"); resp_writable = 0;
    drain("R11 ovf drain");

    // R6 rewrite under pending invalidation
    set_req(1, 6, 0); step(OP_ALLOC, "R6 alloc");
    pm_resp = 1; step(OP_SERVICE, "R6 service"); pm_resp = 0;
    snoop_pulse(1, 0);
    set_req(2, 2, 0); step(OP_ADD, "R6 upgrade");
    set_req(3, 3, 0); step(OP_ADD, "R6 store-cond");
    set_req(4, 2, 0); step(OP_ADD, "R6 fill deferred");
    set_req(5, 0, 0); step(OP_ADD, "R6 deferred full");
    drain("R6 drain");

    // R8 uncacheable
    req_uncache = 1; set_req(9, 0, 0); step(OP_ALLOC, "R8 unc alloc"); req_uncache = 0;
    set_req(10, 0, 0); step(OP_ADD, "R8 unc add");
    drain("R8 drain");

    // random episodes
    for (int ep = 0; ep < 60; ep++) begin
      set_req($urandom_range(0, 15), ($urandom_range(0, 9) == 0) ? 5 : $urandom_range(0, 4), 0);
      req_uncache = ($urandom_range(0, 9) == 0);
      req_addr = $urandom;
      step(OP_ALLOC, "R2 rand alloc");
      req_uncache = 0;
      for (int s = 0; s < 25; s++) begin
        int r;
        r = $urandom_range(0, 99);
        is_forward = ($urandom_range(0, 7) == 0);
        pm_resp = $urandom_range(0, 1);
        resp_writable = $urandom_range(0, 1);
        now_time = TIME_W'($urandom_range(0, 300));
        set_req($urandom_range(0, 15), $urandom_range(0, 6), $urandom_range(0, 5) == 0);
        if (r < 50) step(OP_ADD, "R4 rand add");
        else if (r < 60) step(OP_SERVICE, "R9 rand service");
        else if (r < 66) snoop_pulse($urandom_range(0, 1), $urandom_range(0, 1));
        else if (r < 74) step(OP_RESP, "R11 rand resp");
        else if (r < 84) step(OP_POP, "R13 rand pop");
        else if (r < 92) step(OP_PROMOTE, "R10 rand promote");
        else if (r < 96) step(op_e'($urandom_range(8, 9)), "R14 rand ds");
        else step(OP_DEALLOC, "R12 rand dealloc");
      end
      is_forward = 0;
      drain("R12 rand drain");
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule